// File: doc/BRIEF.md
# Instruction Format Decoder

This block takes one 32-bit fixed-length instruction word and tells the rest of a pipeline which of three encodings it uses: register-to-register, immediate, or jump. The choice rests only on the 6-bit opcode at the top of the word. The block then cuts the low 26 bits into the fields that belong to that encoding. Fields that have no meaning for the chosen encoding are driven to zero, so later stages never see stale bits.

For immediate-format words it also builds three 32-bit operand variants from the 16-bit constant:
- a sign-extended form, for arithmetic and address offsets;
- a zero-extended form, for logical operations;
- an upper-half form, with the constant in the high half and zeros below.

Together the upper-half form and the zero-extended form cover a two-instruction sequence that builds any 32-bit constant: an upper load followed by an or-immediate.

A parameter selects the output stage. With the stage on (the default), every output is captured one clock after a strobed input, together with an output valid flag. With the stage off, the outputs follow the input directly.

Top module: `insn_decoder`

## Requirements
- R1: The opcode is insn_i[31:26]. An opcode of 0 gives fmt_o = 2'b00 (register format). An opcode of 2 or 3 gives fmt_o = 2'b10 (jump format). Every other opcode gives fmt_o = 2'b01 (immediate format). The code 2'b11 never appears.
- R2: In register format, rs_o = insn_i[25:21], rt_o = insn_i[20:16], rd_o = insn_i[15:11], shamt_o = insn_i[10:6] and funct_o = insn_i[5:0].
- R3: In immediate format, rs_o = insn_i[25:21] and rt_o = insn_i[20:16], and the 16-bit constant is insn_i[15:0]. In this format rd_o, shamt_o, funct_o and jtarget_o are zero.
- R4: In jump format, jtarget_o = insn_i[25:0].
- R5: In immediate format, imm_sext_o is the constant with bit 15 copied into bits 31..16. For example, 0xFFFF yields 0xFFFFFFFF (-1).
- R6: In immediate format, imm_zext_o is the constant with bits 31..16 cleared.
- R7: In immediate format, imm_upper_o holds the constant in bits 31..16 and zero in bits 15..0. For example, 61 yields 0x003D0000, and OR-ing the zero-extended form of 2304 into it gives 0x003D0900.
- R8: In register format, all immediates and jtarget_o are zero. In jump format, rs_o, rt_o, rd_o, shamt_o, funct_o and all immediates are zero.
- R9: With REGISTERED=1, valid_o equals valid_i of the previous clock. The decoded outputs load only on a clock where valid_i is high, and otherwise hold their value.
- R10: While rst_ni is low, valid_o and every decoded output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word strobe |
| insn_i | input | 32 | Instruction word |
| valid_o | output | 1 | Decoded outputs are fresh |
| fmt_o | output | 2 | Format: 00 register, 01 immediate, 10 jump |
| rs_o | output | 5 | First source register specifier |
| rt_o | output | 5 | Second source / target register specifier |
| rd_o | output | 5 | Destination register specifier |
| shamt_o | output | 5 | Shift amount |
| funct_o | output | 6 | Function code |
| imm_sext_o | output | 32 | Sign-extended immediate |
| imm_zext_o | output | 32 | Zero-extended immediate |
| imm_upper_o | output | 32 | Constant placed in the upper half |
| jtarget_o | output | 26 | Jump target field |

## Verification
The bench sweeps all 64 opcodes against several payload patterns, so the neighbours 1 and 4 of the jump opcodes are covered; a classifier that matched too wide a range would mislabel them. Payloads with bit 15 set and clear, plus the all-ones constant, expose sign extension that uses the wrong bit or leaks into the zero-extended form. The six sample words and the upper-load/or-immediate pair pin down exact field values, which catches a shifted field boundary. Hold and mid-run reset sequences show whether an output stage reloads without a strobe or fails to clear.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned SHAMT_W = 5;
  localparam int unsigned FUNCT_W = 6;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned TGT_W   = INSN_W - OPC_W;

  // field positions, most significant first below the opcode
  localparam int unsigned RS_MSB    = TGT_W - 1;
  localparam int unsigned RT_MSB    = RS_MSB - REG_W;
  localparam int unsigned RD_MSB    = RT_MSB - REG_W;
  localparam int unsigned SHAMT_MSB = RD_MSB - REG_W;
  localparam int unsigned FUNCT_MSB = SHAMT_MSB - SHAMT_W;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JMP0 = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JMP1 = 6'd3;

  typedef enum logic [1:0] {
    FMT_REG = 2'b00,
    FMT_IMM = 2'b01,
    FMT_JMP = 2'b10
  } fmt_e;

  typedef struct packed {
    fmt_e               fmt;
    logic [REG_W-1:0]   rs;
    logic [REG_W-1:0]   rt;
    logic [REG_W-1:0]   rd;
    logic [SHAMT_W-1:0] shamt;
    logic [FUNCT_W-1:0] funct;
    logic [INSN_W-1:0]  imm_sext;
    logic [INSN_W-1:0]  imm_zext;
    logic [INSN_W-1:0]  imm_upper;
    logic [TGT_W-1:0]   jtarget;
  } dec_t;
endpackage

// File: rtl/insn_fmt_classify.sv
module insn_fmt_classify
  import insn_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output fmt_e             fmt_o
);
  always_comb begin
    if (opcode_i == OPC_REG)
      fmt_o = FMT_REG;
    else if (opcode_i == OPC_JMP0 || opcode_i == OPC_JMP1)
      fmt_o = FMT_JMP;
    else
      fmt_o = FMT_IMM;
  end
endmodule

// File: rtl/insn_field_split.sv
module insn_field_split
  import insn_dec_pkg::*;
(
  input  logic [TGT_W-1:0]   body_i,
  input  fmt_e               fmt_i,
  output logic [REG_W-1:0]   rs_o,
  output logic [REG_W-1:0]   rt_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [SHAMT_W-1:0] shamt_o,
  output logic [FUNCT_W-1:0] funct_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic               imm_en_o,
  output logic [TGT_W-1:0]   jtarget_o
);
  logic is_reg, is_imm, is_jmp;

  assign is_reg = (fmt_i == FMT_REG);
  assign is_imm = (fmt_i == FMT_IMM);
  assign is_jmp = (fmt_i == FMT_JMP);

  always_comb begin
    rs_o      = '0;
    rt_o      = '0;
    rd_o      = '0;
    shamt_o   = '0;
    funct_o   = '0;
    imm_o     = '0;
    jtarget_o = '0;
    if (is_reg || is_imm) begin
      rs_o = body_i[RS_MSB -: REG_W];
      rt_o = body_i[RT_MSB -: REG_W];
    end
    if (is_reg) begin
      rd_o    = body_i[RD_MSB -: REG_W];
      shamt_o = body_i[SHAMT_MSB -: SHAMT_W];
      funct_o = body_i[FUNCT_MSB -: FUNCT_W];
    end
    if (is_imm) imm_o = body_i[IMM_W-1:0];
    if (is_jmp) jtarget_o = body_i;
  end

  assign imm_en_o = is_imm;
endmodule

// File: rtl/insn_imm_build.sv
module insn_imm_build
  import insn_dec_pkg::*;
(
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              en_i,
  output logic [INSN_W-1:0] sext_o,
  output logic [INSN_W-1:0] zext_o,
  output logic [INSN_W-1:0] upper_o
);
  localparam int unsigned EXT_W = INSN_W - IMM_W;

  logic [IMM_W-1:0] imm_q;
  logic             sign;

  assign imm_q = en_i ? imm_i : '0;
  assign sign  = imm_q[IMM_W-1];

  assign sext_o[IMM_W-1:0] = imm_q;
  assign zext_o[IMM_W-1:0] = imm_q;

  for (genvar i = 0; i < EXT_W; i++) begin : g_ext
    assign sext_o[IMM_W+i] = sign;
    assign zext_o[IMM_W+i] = 1'b0;
  end

  assign upper_o = {imm_q, {(INSN_W-IMM_W){1'b0}}};
endmodule

// File: rtl/insn_out_stage.sv
module insn_out_stage
  import insn_dec_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  dec_t dec_i,
  output logic valid_o,
  output dec_t dec_o
);
  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        dec_o   <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) dec_o <= dec_i;
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign dec_o   = dec_i;
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [31:0]        insn_i,
  output logic               valid_o,
  output logic [1:0]         fmt_o,
  output logic [4:0]         rs_o,
  output logic [4:0]         rt_o,
  output logic [4:0]         rd_o,
  output logic [4:0]         shamt_o,
  output logic [5:0]         funct_o,
  output logic [31:0]        imm_sext_o,
  output logic [31:0]        imm_zext_o,
  output logic [31:0]        imm_upper_o,
  output logic [25:0]        jtarget_o
);
  fmt_e             fmt;
  logic [IMM_W-1:0] imm_raw;
  logic             imm_en;
  dec_t             dec_d, dec_q;

  insn_fmt_classify u_classify (
    .opcode_i (insn_i[INSN_W-1 -: OPC_W]),
    .fmt_o    (fmt)
  );

  insn_field_split u_split (
    .body_i    (insn_i[TGT_W-1:0]),
    .fmt_i     (fmt),
    .rs_o      (dec_d.rs),
    .rt_o      (dec_d.rt),
    .rd_o      (dec_d.rd),
    .shamt_o   (dec_d.shamt),
    .funct_o   (dec_d.funct),
    .imm_o     (imm_raw),
    .imm_en_o  (imm_en),
    .jtarget_o (dec_d.jtarget)
  );

  insn_imm_build u_imm (
    .imm_i   (imm_raw),
    .en_i    (imm_en),
    .sext_o  (dec_d.imm_sext),
    .zext_o  (dec_d.imm_zext),
    .upper_o (dec_d.imm_upper)
  );

  assign dec_d.fmt = fmt;

  insn_out_stage #(.REGISTERED(REGISTERED)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .dec_i   (dec_d),
    .valid_o (valid_o),
    .dec_o   (dec_q)
  );

  assign fmt_o       = dec_q.fmt;
  assign rs_o        = dec_q.rs;
  assign rt_o        = dec_q.rt;
  assign rd_o        = dec_q.rd;
  assign shamt_o     = dec_q.shamt;
  assign funct_o     = dec_q.funct;
  assign imm_sext_o  = dec_q.imm_sext;
  assign imm_zext_o  = dec_q.imm_zext;
  assign imm_upper_o = dec_q.imm_upper;
  assign jtarget_o   = dec_q.jtarget;
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk #(
  parameter bit REGISTERED = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] insn_i,
  input logic        valid_o,
  input logic [1:0]  fmt_o,
  input logic [4:0]  rs_o,
  input logic [4:0]  rt_o,
  input logic [4:0]  rd_o,
  input logic [4:0]  shamt_o,
  input logic [5:0]  funct_o,
  input logic [31:0] imm_sext_o,
  input logic [31:0] imm_zext_o,
  input logic [31:0] imm_upper_o,
  input logic [25:0] jtarget_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_FMT_NO_11: assert property (@(posedge clk_i) disable iff (!rst_ni) fmt_o != 2'b11); // R1
  AST_SEXT_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni) fmt_o == 2'b01 |-> imm_sext_o == {{16{imm_zext_o[15]}}, imm_zext_o[15:0]}); // R5
  AST_ZEXT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) imm_zext_o[31:16] == 16'h0); // R6
  AST_UPPER_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni) imm_upper_o == {imm_sext_o[15:0], 16'h0}); // R7
  AST_REG_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni) fmt_o == 2'b00 |-> imm_zext_o == 32'h0 && imm_sext_o == 32'h0 && jtarget_o == 26'h0); // R8
  AST_JMP_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni) fmt_o == 2'b10 |-> (rs_o | rt_o | rd_o | shamt_o) == 5'h0 && funct_o == 6'h0 && imm_zext_o == 32'h0); // R8
  AST_IMM_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni) fmt_o == 2'b01 |-> (rd_o | shamt_o) == 5'h0 && funct_o == 6'h0 && jtarget_o == 26'h0); // R3
  AST_RST_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> !valid_o && fmt_o == 2'b00 && imm_sext_o == 32'h0 && jtarget_o == 26'h0); // R10

  if (REGISTERED) begin : g_seq
    AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni) armed |-> valid_o == $past(valid_i)); // R9
    AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) armed && !$past(valid_i) |-> $stable(fmt_o) && $stable(imm_zext_o) && $stable(jtarget_o)); // R9
    AST_FMT_REG: assert property (@(posedge clk_i) disable iff (!rst_ni) armed && $past(valid_i) && $past(insn_i[31:26]) == 6'd0 |-> fmt_o == 2'b00); // R1
    AST_FMT_JMP: assert property (@(posedge clk_i) disable iff (!rst_ni) armed && $past(valid_i) && $past(insn_i[31:27]) == 5'b00001 |-> fmt_o == 2'b10); // R1
    AST_RS_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni) armed && $past(valid_i) && fmt_o != 2'b10 |-> rs_o == $past(insn_i[25:21])); // R2
    AST_JT_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni) armed && $past(valid_i) && fmt_o == 2'b10 |-> jtarget_o == $past(insn_i[25:0])); // R4
  end else begin : g_comb
    AST_VALID_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o == valid_i); // R9
    AST_FMT_REG: assert property (@(posedge clk_i) disable iff (!rst_ni) insn_i[31:26] == 6'd0 |-> fmt_o == 2'b00); // R1
    AST_RS_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni) fmt_o != 2'b10 |-> rs_o == insn_i[25:21]); // R2
    AST_JT_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni) fmt_o == 2'b10 |-> jtarget_o == insn_i[25:0]); // R4
    logic unused_armed;
    assign unused_armed = armed;
  end
endmodule

bind insn_decoder insn_decoder_chk #(.REGISTERED(REGISTERED)) u_chk (.*);

// File: tb/tb_insn_decoder.sv
module tb_insn_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = 32'h0;
  logic        valid_o;
  logic [1:0]  fmt_o;
  logic [4:0]  rs_o, rt_o, rd_o, shamt_o;
  logic [5:0]  funct_o;
  logic [31:0] imm_sext_o, imm_zext_o, imm_upper_o;
  logic [25:0] jtarget_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  insn_decoder #(.REGISTERED(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .valid_o(valid_o), .fmt_o(fmt_o), .rs_o(rs_o), .rt_o(rt_o), .rd_o(rd_o),
    .shamt_o(shamt_o), .funct_o(funct_o), .imm_sext_o(imm_sext_o),
    .imm_zext_o(imm_zext_o), .imm_upper_o(imm_upper_o), .jtarget_o(jtarget_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // strobe one word; returns at the negedge after the capturing posedge
  task automatic apply(logic [31:0] w);
    @(negedge clk);
    insn_i  = w;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic expect_word(logic [31:0] w);
    int unsigned op, rs, rt, rd, sh, fn, imm, tgt, f;
    logic [31:0] sx, zx, up;
    op  = w / 67108864;
    rs  = (w / 2097152) % 32;
    rt  = (w / 65536) % 32;
    rd  = (w / 2048) % 32;
    sh  = (w / 64) % 32;
    fn  = w % 64;
    imm = w % 65536;
    tgt = w % 67108864;
    f   = (op == 0) ? 0 : ((op == 2 || op == 3) ? 2 : 1);
    zx  = (f == 1) ? imm : 0;
    sx  = (f == 1) ? ((imm >= 32768) ? 32'(imm + 32'hFFFF0000) : imm) : 0;
    up  = zx * 65536;
    chk("R9", "valid_o", 32'(valid_o), 32'd1);
    chk("R1", "fmt_o", 32'(fmt_o), f);
    chk("R2", "rs_o", 32'(rs_o), (f != 2) ? rs : 0);
    chk("R2", "rt_o", 32'(rt_o), (f != 2) ? rt : 0);
    chk("R3", "rd_o", 32'(rd_o), (f == 0) ? rd : 0);
    chk("R3", "shamt_o", 32'(shamt_o), (f == 0) ? sh : 0);
    chk("R3", "funct_o", 32'(funct_o), (f == 0) ? fn : 0);
    chk("R5", "imm_sext_o", imm_sext_o, sx);
    chk("R6", "imm_zext_o", imm_zext_o, zx);
    chk("R7", "imm_upper_o", imm_upper_o, up);
    chk("R4", "jtarget_o", 32'(jtarget_o), (f == 2) ? tgt : 0);
    chk("R8", "jtarget_o clean", 32'(jtarget_o), (f == 2) ? tgt : 0);
  endtask

  task automatic reset_zero_check(string tag);
    chk("R10", {tag, " valid_o"}, 32'(valid_o), 0);
    chk("R10", {tag, " fmt_o"}, 32'(fmt_o), 0);
    chk("R10", {tag, " fields"}, 32'({rs_o, rt_o, rd_o, shamt_o, funct_o}), 0);
    chk("R10", {tag, " imm_sext_o"}, imm_sext_o, 0);
    chk("R10", {tag, " imm_upper_o"}, imm_upper_o, 0);
    chk("R10", {tag, " jtarget_o"}, 32'(jtarget_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] lfsr;
    logic [31:0] upper_val;
    pats[0] = 32'h03FF_FFFF;
    pats[1] = 32'h0000_0000;
    pats[2] = 32'h02A5_5A5A;
    pats[3] = 32'h0155_A5A5;

    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    reset_zero_check("reset");
    rst_ni = 1'b1;
    @(negedge clk);

    // six sample words with literal expectations
    apply(32'h0000_1025);
    chk("R1", "w0 fmt", 32'(fmt_o), 0);
    chk("R2", "w0 rd/funct", {rd_o, funct_o}, {5'd2, 6'd37});
    expect_word(32'h0000_1025);
    apply(32'h0005_402A);
    chk("R2", "w1 rt/rd/funct", {rt_o, rd_o, funct_o}, {5'd5, 5'd8, 6'd42});
    expect_word(32'h0005_402A);
    apply(32'h1100_0003);
    chk("R1", "w2 fmt", 32'(fmt_o), 1);
    chk("R3", "w2 rs", 32'(rs_o), 8);
    chk("R5", "w2 imm", imm_sext_o, 3);
    expect_word(32'h1100_0003);
    apply(32'h0044_1020);
    chk("R2", "w3 rs/rt/rd/funct", {rs_o, rt_o, rd_o, funct_o}, {5'd2, 5'd4, 5'd2, 6'd32});
    expect_word(32'h0044_1020);
    apply(32'h20A5_FFFF);
    chk("R3", "w4 rs/rt", {rs_o, rt_o}, {5'd5, 5'd5});
    chk("R5", "w4 imm -1", imm_sext_o, 32'hFFFF_FFFF);
    chk("R6", "w4 zext", imm_zext_o, 32'h0000_FFFF);
    expect_word(32'h20A5_FFFF);
    apply(32'h0810_0001);
    chk("R1", "w5 fmt", 32'(fmt_o), 2);
    chk("R4", "w5 target", 32'(jtarget_o), 32'd1048577);
    expect_word(32'h0810_0001);

    // constant-building pair: upper load of 61, then or-immediate 2304
    apply({6'd15, 5'd0, 5'd16, 16'd61});
    chk("R7", "upper 61", imm_upper_o, 32'h003D_0000);
    upper_val = imm_upper_o;
    apply({6'd13, 5'd16, 5'd16, 16'd2304});
    chk("R7", "upper|zext", upper_val | imm_zext_o, 32'h003D_0900);

    // full opcode sweep
    for (int op = 0; op < 64; op++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] w;
        w = {6'(op), pats[p][25:0]};
        apply(w);
        expect_word(w);
      end
    end

    // pseudo-random words
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 300; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      apply(lfsr);
      expect_word(lfsr);
    end

    // hold without strobe
    apply(32'h20A5_8001);
    insn_i = 32'h0810_0001;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "hold valid_o", 32'(valid_o), 0);
    chk("R9", "hold fmt", 32'(fmt_o), 1);
    chk("R9", "hold sext", imm_sext_o, 32'hFFFF_8001);
    chk("R9", "hold jtarget", 32'(jtarget_o), 0);

    // mid-run reset
    apply(32'h0C12_3456);
    chk("R4", "pre-reset target", 32'(jtarget_o), 32'h0012_3456);
    rst_ni = 1'b0;
    #1;
    reset_zero_check("mid-run");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    reset_zero_check("after release");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule